// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block lets on-chip logic read and write 16-bit PHY registers that have no memory-mapped path. The PHY side is reached through one 20-bit control word and one 17-bit status word. The control word carries four strobes in its top bits and an address or data value in its low 16 bits. The status word returns a single acknowledge bit and 16 bits of read data.

A requester raises `req_i` for one cycle while the sequencer is idle. With that pulse it supplies a direction flag, an address and, for a write, a data value. The sequencer splits the access into phases, and each phase has its own request/acknowledge handshake.

- A write runs three phases: address capture, then data capture, then the write strobe.
- A read runs two phases: address capture, then the read strobe, which returns the status data.

In every phase the strobe is held until acknowledge is seen high. The strobe is then removed, and the sequencer waits for acknowledge to return low. Each wait polls acknowledge a bounded number of times at a fixed spacing. If the expected level never appears, the access is abandoned, the control word is cleared and the error flag is reported together with done.

Top module: `phy_reg_seq`

## Requirements
- R1: While reset is held and after its release, `done_o` and `err_o` are low and `phy_ctl_o` is all zeros.
- R2: A write raises, in this order:
  - bit 16 (address capture), with the address in bits 15:0;
  - bit 17 (data capture), with the write data in bits 15:0;
  - bit 18 (write strobe).
- R3: A read raises bit 16 (address capture) with the address in bits 15:0, then bit 19 (read strobe). `rdata_o` takes `phy_stat_i[15:0]` as sampled when the acknowledge `phy_stat_i[16]` is found high during the read strobe. It keeps that value until the next read completes.
- R4: A strobe is removed only after acknowledge has been seen high, or when the access aborts. The next phase starts only after acknowledge has been seen low.
- R5: At most one of `phy_ctl_o[19:16]` is high in any cycle.
- R6: Each acknowledge wait checks the level at most `MAX_POLLS` times, `POLL_GAP` cycles apart, with the first check in the first cycle of the wait. If no check matches, the access times out. This applies to waits for a high level and to waits for a low level.
- R7: `phy_ctl_o` is all zeros whenever `done_o` is high, including after a timeout, and it stays zero while the sequencer is idle.
- R8: The request inputs are sampled only in the idle cycle that accepts a request. Pulses of `req_i` and changes of `addr_i`, `wr_i` or `wdata_i` during an access have no effect.
- R9: Every access ends with exactly one single-cycle `done_o` pulse. `err_o` is high only together with `done_o`, and only when that access timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled only when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with `done_o` |
| rdata_o | output | 16 | Data from the last completed read |
| phy_ctl_o | output | 20 | Control word: [19] read strobe, [18] write strobe, [17] data capture, [16] address capture, [15:0] field |
| phy_stat_i | input | 17 | Status word: [16] acknowledge, [15:0] read data |

## Verification
The properties make no assumption about when acknowledge moves. They bind only the control word, done and error to the sequencer's own progress, so a PHY whose acknowledge is stuck at either level still keeps them true. The bench's PHY model echoes any strobe onto acknowledge one cycle later and presents read data in that same cycle. Requests are driven at the falling edge, so the idle-cycle sampling is unambiguous. Two fault modes pin acknowledge low or high to exercise the timeout on a rising wait and on a falling wait.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int FIELD_W = 16;
  localparam int STB_W   = 4;
  localparam int CTL_W   = FIELD_W + STB_W;
  localparam int STAT_W  = FIELD_W + 1;
  localparam int ACK_BIT = FIELD_W;

  // Strobe nibble positions follow the control word: [3]=rd [2]=wr [1]=cap data [0]=cap addr
  localparam logic [STB_W-1:0] STB_NONE    = 4'b0000;
  localparam logic [STB_W-1:0] STB_CAP_ADR = 4'b0001;
  localparam logic [STB_W-1:0] STB_CAP_DAT = 4'b0010;
  localparam logic [STB_W-1:0] STB_WR      = 4'b0100;
  localparam logic [STB_W-1:0] STB_RD      = 4'b1000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_SET,
    ST_ADR_CAP,
    ST_ADR_REL,
    ST_DAT_SET,
    ST_DAT_CAP,
    ST_DAT_REL,
    ST_WR_STB,
    ST_WR_REL,
    ST_RD_STB,
    ST_RD_REL,
    ST_FIN
  } seq_state_e;

  function automatic logic [CTL_W-1:0] ctl_word(input logic [STB_W-1:0] stb,
                                                input logic [FIELD_W-1:0] fld);
    return {stb, fld};
  endfunction

endpackage

// File: rtl/phy_ack_waiter.sv
module phy_ack_waiter #(
  parameter int POLL_GAP  = 200,
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic lvl_i,
  input  logic ack_i,
  output logic hit_o,
  output logic tmo_o
);

  localparam int GAP_W  = $clog2(POLL_GAP) + 1;
  localparam int POLL_W = $clog2(MAX_POLLS) + 1;
  localparam logic [GAP_W-1:0]  GAP_RELOAD = GAP_W'(POLL_GAP - 1);
  localparam logic [POLL_W-1:0] LAST_POLL  = POLL_W'(MAX_POLLS - 1);

  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic check, match;

  always_comb begin
    check = active_i && (gap_q == '0);
    match = (ack_i == lvl_i);
    hit_o = check && match;
    tmo_o = check && !match && (poll_q == LAST_POLL);
  end

  always_comb begin
    gap_d  = gap_q;
    poll_d = poll_q;
    if (!active_i || hit_o || tmo_o) begin
      gap_d  = '0;
      poll_d = '0;
    end else if (check) begin
      gap_d  = GAP_RELOAD;
      poll_d = poll_q + 1'b1;
    end else begin
      gap_d  = gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else begin
      gap_q  <= gap_d;
      poll_q <= poll_d;
    end
  end

  // R6: the poll count never passes the configured number of checks
  p_poll_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (poll_q < POLL_W'(MAX_POLLS)));

  // R6: a wait ends by match or by timeout, never both
  p_verdict_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && tmo_o));

endmodule

// File: rtl/phy_req_latch.sv
module phy_req_latch
  import phy_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] addr_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic               wr_o,
  output logic [FIELD_W-1:0] addr_o,
  output logic [FIELD_W-1:0] wdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      wr_o    <= wr_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [FIELD_W-1:0] addr_i,
  input  logic               lat_wr_i,
  input  logic [FIELD_W-1:0] lat_addr_i,
  input  logic [FIELD_W-1:0] lat_data_i,
  input  logic               hit_i,
  input  logic               tmo_i,
  input  logic [FIELD_W-1:0] stat_data_i,
  output logic               accept_o,
  output logic               wait_en_o,
  output logic               wait_lvl_o,
  output logic [CTL_W-1:0]   ctl_o,
  output logic               done_o,
  output logic               err_o,
  output logic [FIELD_W-1:0] rdata_o
);

  seq_state_e         state_q, state_d;
  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic               err_q, err_d;
  logic [FIELD_W-1:0] rdata_q;
  logic               rd_load;

  always_comb begin
    wait_en_o  = 1'b0;
    wait_lvl_o = 1'b0;
    unique case (state_q)
      ST_ADR_CAP, ST_DAT_CAP, ST_WR_STB, ST_RD_STB: begin
        wait_en_o  = 1'b1;
        wait_lvl_o = 1'b1;
      end
      ST_ADR_REL, ST_DAT_REL, ST_WR_REL, ST_RD_REL: begin
        wait_en_o  = 1'b1;
        wait_lvl_o = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    ctl_d    = ctl_q;
    err_d    = err_q;
    rd_load  = 1'b0;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        err_d    = 1'b0;
        ctl_d    = ctl_word(STB_NONE, addr_i);
        state_d  = ST_ADR_SET;
      end
      ST_ADR_SET: begin
        ctl_d   = ctl_word(STB_CAP_ADR, lat_addr_i);
        state_d = ST_ADR_CAP;
      end
      ST_ADR_CAP: if (hit_i) begin
        ctl_d   = ctl_word(STB_NONE, lat_addr_i);
        state_d = ST_ADR_REL;
      end
      ST_ADR_REL: if (hit_i) begin
        if (lat_wr_i) begin
          ctl_d   = ctl_word(STB_NONE, lat_data_i);
          state_d = ST_DAT_SET;
        end else begin
          ctl_d   = ctl_word(STB_RD, '0);
          state_d = ST_RD_STB;
        end
      end
      ST_DAT_SET: begin
        ctl_d   = ctl_word(STB_CAP_DAT, lat_data_i);
        state_d = ST_DAT_CAP;
      end
      ST_DAT_CAP: if (hit_i) begin
        ctl_d   = ctl_word(STB_NONE, lat_data_i);
        state_d = ST_DAT_REL;
      end
      ST_DAT_REL: if (hit_i) begin
        ctl_d   = ctl_word(STB_WR, '0);
        state_d = ST_WR_STB;
      end
      ST_WR_STB: if (hit_i) begin
        ctl_d   = ctl_word(STB_NONE, lat_data_i);
        state_d = ST_WR_REL;
      end
      ST_WR_REL: if (hit_i) begin
        ctl_d   = '0;
        state_d = ST_FIN;
      end
      ST_RD_STB: if (hit_i) begin
        rd_load = 1'b1;
        ctl_d   = '0;
        state_d = ST_RD_REL;
      end
      ST_RD_REL: if (hit_i) begin
        state_d = ST_FIN;
      end
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (wait_en_o && tmo_i) begin
      rd_load = 1'b0;
      ctl_d   = '0;
      err_d   = 1'b1;
      state_d = ST_FIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_load) begin
      rdata_q <= stat_data_i;
    end
  end

  assign ctl_o   = ctl_q;
  assign done_o  = (state_q == ST_FIN);
  assign err_o   = done_o && err_q;
  assign rdata_o = rdata_q;

  // R9: done lasts exactly one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: error never appears without done
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R7: the control word is clear whenever an access completes
  p_fin_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ctl_o == '0));

endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq
  import phy_seq_pkg::*;
#(
  parameter int POLL_GAP  = 200,
  parameter int MAX_POLLS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic                 wr_i,
  input  logic [FIELD_W-1:0]   addr_i,
  input  logic [FIELD_W-1:0]   wdata_i,
  output logic                 done_o,
  output logic                 err_o,
  output logic [FIELD_W-1:0]   rdata_o,
  output logic [CTL_W-1:0]     phy_ctl_o,
  input  logic [STAT_W-1:0]    phy_stat_i
);

  logic               accept, wait_en, wait_lvl, hit, tmo;
  logic               lat_wr;
  logic [FIELD_W-1:0] lat_addr, lat_data;
  logic               ack;

  assign ack = phy_stat_i[ACK_BIT];

  phy_req_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_o    (lat_wr),
    .addr_o  (lat_addr),
    .wdata_o (lat_data)
  );

  phy_ack_waiter #(
    .POLL_GAP  (POLL_GAP),
    .MAX_POLLS (MAX_POLLS)
  ) u_waiter (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (wait_en),
    .lvl_i    (wait_lvl),
    .ack_i    (ack),
    .hit_o    (hit),
    .tmo_o    (tmo)
  );

  phy_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .lat_wr_i    (lat_wr),
    .lat_addr_i  (lat_addr),
    .lat_data_i  (lat_data),
    .hit_i       (hit),
    .tmo_i       (tmo),
    .stat_data_i (phy_stat_i[FIELD_W-1:0]),
    .accept_o    (accept),
    .wait_en_o   (wait_en),
    .wait_lvl_o  (wait_lvl),
    .ctl_o       (phy_ctl_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o)
  );

  // R5: never more than one strobe at a time
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctl_o[CTL_W-1:FIELD_W]));

  // R4: a strobe is withdrawn only after acknowledge was seen high, or on abort
  p_strobe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|phy_ctl_o[CTL_W-1:FIELD_W]) |-> ($past(ack) || err_o));

endmodule

// File: tb/phy_reg_seq_tb.sv
`timescale 1ns/1ps
module phy_reg_seq_tb;

  localparam int GAP  = 200;
  localparam int MAXP = 10;
  localparam int TMO_LAT_LO = (MAXP - 1) * GAP + 2;
  localparam int TMO_LAT_HI = (MAXP - 1) * GAP + 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr;
  logic [15:0] addr, wdata;
  logic        done, err;
  logic [15:0] rdata;
  logic [19:0] ctl;
  logic [16:0] stat;

  always #2.5 clk = ~clk;

  phy_reg_seq #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .done_o(done), .err_o(err), .rdata_o(rdata),
    .phy_ctl_o(ctl), .phy_stat_i(stat)
  );

  // PHY model: 0 = normal echo, 1 = acknowledge stuck low, 2 = stuck high
  logic [1:0]  phy_mode;
  logic        ack_q;
  logic [15:0] sdata_q, lat_a, lat_d;
  logic [15:0] pmem [16];
  logic [19:0] ctl_prev;
  logic [2:0]  slog [64];
  int          log_n;
  logic [15:0] seen_a, seen_d;

  assign stat = {ack_q, sdata_q};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0; sdata_q <= 16'h0; lat_a <= 16'h0; lat_d <= 16'h0;
      ctl_prev <= 20'h0; log_n <= 0; seen_a <= 16'h0; seen_d <= 16'h0;
      for (int i = 0; i < 16; i++) pmem[i] <= 16'h0;
    end else begin
      ctl_prev <= ctl;
      case (phy_mode)
        2'd1:    ack_q <= 1'b0;
        2'd2:    ack_q <= 1'b1;
        default: ack_q <= |ctl[19:16];
      endcase
      sdata_q <= ctl[19] ? pmem[lat_a[3:0]] : 16'hBAD0;
      if (ctl[16] && !ctl_prev[16]) begin
        lat_a <= ctl[15:0]; seen_a <= ctl[15:0];
        slog[log_n % 64] <= 3'd1; log_n <= log_n + 1;
      end
      if (ctl[17] && !ctl_prev[17]) begin
        lat_d <= ctl[15:0]; seen_d <= ctl[15:0];
        slog[log_n % 64] <= 3'd2; log_n <= log_n + 1;
      end
      if (ctl[18] && !ctl_prev[18]) begin
        pmem[lat_a[3:0]] <= lat_d;
        slog[log_n % 64] <= 3'd3; log_n <= log_n + 1;
      end
      if (ctl[19] && !ctl_prev[19]) begin
        slog[log_n % 64] <= 3'd4; log_n <= log_n + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one access; returns cycles from acceptance to done, and error flag
  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d,
                        output int lat, output bit e);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 0; e = 1'b0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (done) begin e = err; break; end
      if (lat > 5000) begin
        chk(1'b0, "R9", "done never seen", 32'(lat), 32'd0);
        break;
      end
    end
    chk(ctl == 20'h0, "R7", "control word at done", 32'(ctl), 32'h0);
    @(negedge clk);
    chk(!done, "R9", "done is a single pulse", 32'(done), 32'h0);
  endtask

  // table: {write, address, data}
  localparam logic [32:0] VEC [8] = '{
    {1'b1, 16'h1005, 16'h00A5},
    {1'b1, 16'h100D, 16'h0001},
    {1'b0, 16'h1005, 16'h0000},
    {1'b1, 16'h0003, 16'hFFFF},
    {1'b0, 16'h0003, 16'h0000},
    {1'b0, 16'h100D, 16'h0000},
    {1'b1, 16'h1005, 16'h0000},
    {1'b0, 16'h1005, 16'h0000}
  };

  logic [15:0] shadow [16];

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int lat, n0;
    bit e;
    logic [15:0] keep;
    req = 0; wr = 0; addr = 0; wdata = 0; phy_mode = 2'd0; rst_n = 1'b0;
    for (int i = 0; i < 16; i++) shadow[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(!done && !err && ctl == 20'h0, "R1", "outputs in reset", {11'h0, done, err, ctl[18:0]}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !err && ctl == 20'h0, "R1", "outputs after reset", {11'h0, done, err, ctl[18:0]}, 32'h0);

    for (int v = 0; v < 8; v++) begin
      n0 = log_n;
      access(VEC[v][32], VEC[v][31:16], VEC[v][15:0], lat, e);
      chk(!e, "R9", "no error on normal access", 32'(e), 32'h0);
      chk(seen_a == VEC[v][31:16], "R2", "address field at capture", 32'(seen_a), 32'(VEC[v][31:16]));
      if (VEC[v][32]) begin
        shadow[VEC[v][19:16]] = VEC[v][15:0];
        chk(log_n - n0 == 3, "R2", "write strobe count", 32'(log_n - n0), 32'd3);
        chk(slog[n0 % 64] == 3'd1 && slog[(n0 + 1) % 64] == 3'd2 && slog[(n0 + 2) % 64] == 3'd3,
            "R2", "write strobe order", {slog[n0 % 64], slog[(n0 + 1) % 64], slog[(n0 + 2) % 64]}, 32'o123);
        chk(seen_d == VEC[v][15:0], "R2", "data field at capture", 32'(seen_d), 32'(VEC[v][15:0]));
      end else begin
        chk(log_n - n0 == 2, "R3", "read strobe count", 32'(log_n - n0), 32'd2);
        chk(slog[n0 % 64] == 3'd1 && slog[(n0 + 1) % 64] == 3'd4,
            "R3", "read strobe order", {slog[n0 % 64], slog[(n0 + 1) % 64]}, 32'o14);
        chk(rdata == shadow[VEC[v][19:16]], "R3", "read data", 32'(rdata), 32'(shadow[VEC[v][19:16]]));
      end
    end

    // R3: a write leaves the last read value in place
    keep = rdata;
    access(1'b1, 16'h0002, 16'h5A5A, lat, e);
    chk(rdata == keep, "R3", "read data held across write", 32'(rdata), 32'(keep));

    // R8: request activity during an access is ignored
    n0 = log_n;
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 16'h0007; wdata = 16'h1234;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = 16'h0009; wdata = 16'hFFFF;
    repeat (20) @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    chk(done && !err, "R8", "first access completes", {30'h0, done, err}, 32'h2);
    chk(seen_a == 16'h0007, "R8", "captured address kept", 32'(seen_a), 32'h7);
    chk(seen_d == 16'h1234, "R8", "captured data kept", 32'(seen_d), 32'h1234);
    chk(log_n - n0 == 3, "R8", "only one access ran", 32'(log_n - n0), 32'd3);
    lat = 0;
    repeat (50) begin @(negedge clk); if (done || ctl != 20'h0) lat++; end
    chk(lat == 0, "R8", "no second access started", 32'(lat), 32'h0);
    access(1'b0, 16'h0007, 16'h0, lat, e);
    chk(rdata == 16'h1234 && !e, "R8", "data of kept access", 32'(rdata), 32'h1234);

    // R6: acknowledge stuck low, timeout on a rising wait
    phy_mode = 2'd1;
    access(1'b1, 16'h0004, 16'h4444, lat, e);
    chk(e, "R9", "error on stuck-low timeout", 32'(e), 32'h1);
    chk(lat >= TMO_LAT_LO - 1 && lat <= TMO_LAT_LO + 1, "R6", "stuck-low timeout latency", 32'(lat), 32'(TMO_LAT_LO));

    // R6: acknowledge stuck high, timeout on a falling wait
    phy_mode = 2'd2;
    access(1'b0, 16'h0005, 16'h0, lat, e);
    chk(e, "R9", "error on stuck-high timeout", 32'(e), 32'h1);
    chk(lat >= TMO_LAT_HI - 1 && lat <= TMO_LAT_HI + 1, "R6", "stuck-high timeout latency", 32'(lat), 32'(TMO_LAT_HI));
    chk(ctl == 20'h0, "R7", "control word idle after timeout", 32'(ctl), 32'h0);

    // recovery: error clears on the next good access
    phy_mode = 2'd0;
    repeat (3) @(negedge clk);
    access(1'b0, 16'h0003, 16'h0, lat, e);
    chk(!e, "R9", "error clear after recovery", 32'(e), 32'h0);
    chk(rdata == 16'hFFFF, "R3", "read after recovery", 32'(rdata), 32'hFFFF);

    finish_run();
  end

endmodule